// File: doc/BRIEF.md
# Pulse Record Queue with Processor Handshake

This block sits between a pulse-capture front end and a processor. The front end offers one fixed-width record per cycle, each carrying the leading-edge and trailing-edge times of a captured pulse. The block appends each record to a parameterised queue. A reader state machine moves the oldest record into four 32-bit read words. It then raises a handshake bit, which is also driven out as an interrupt. Software reads the words and clears the bit. The hardware may not replace the words until software has done so.

An 8-bit control/status byte gathers the software-visible controls. It holds an active-low run bit that flushes the whole path, an active-low pause bit that makes the path deaf to new records, the hardware-set handshake bit, and a loss warning. The loss warning rises when a record arrives with nowhere to go. It falls once the queue has room again. Records that are lost are counted in a saturating counter.

Top module: `pulse_rec_fifo`

## Requirements
- R1: After the hardware reset, the control byte reads 0x03 (run=1, paused=no, handshake=0, warning=0), both interrupts are low, all four read words are zero and the loss counter is zero.
- R2: Records are presented in arrival order. Within a record, bits [31:0] appear on `lead_lo_o`, bits [63:32] on `lead_hi_o`, bits [95:64] on `trail_lo_o` and bits [127:96] on `trail_hi_o`.
- R3: A record offered at clock edge E to an empty queue while the handshake bit (control bit 2) is 0 appears on the read words at edge E+1. At that same edge, control bit 2 and `irq_data_o` become 1. Neither is 1 after edge E alone.
- R4: While control bit 2 is 1, the read words do not change. A control write with bit 2 = 0 at edge W clears the bit after W. If the queue is non-empty, the next record is loaded and bit 2 is set again after W+1.
- R5: A control write with bit 2 = 1 never sets the handshake bit. Only the reader sets it.
- R6: While control bit 1 is 0, offered records are neither stored nor counted as lost.
- R7: Writing control bit 0 as 0 empties the queue, clears the handshake bit, the read words, the warning and the loss counter. Records offered while the bit is 0 are discarded without being counted.
- R8: The queue holds DEPTH records in addition to the one being presented. Filling it raises no warning. A record offered while it is full, with no entry leaving in the same cycle, is lost: control bit 3 and `irq_full_o` become 1 and the loss counter increments.
- R9: The warning falls no later than two edges after the reader removes an entry from a full queue.
- R10: The loss counter saturates at its all-ones value.
- R11: Control bits 7:4 read as zero, and writes cannot set bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| rec_valid_i | input | 1 | A record is offered this cycle |
| rec_data_i | input | 4*WORD_W | Offered record, word 0 in the low bits |
| ctl_wr_en_i | input | 1 | Write strobe for the control byte |
| ctl_wr_data_i | input | 8 | Control byte write value |
| ctl_rd_data_o | output | 8 | Control/status byte readback |
| lead_lo_o | output | WORD_W | Leading-edge time, low word |
| lead_hi_o | output | WORD_W | Leading-edge time, high word |
| trail_lo_o | output | WORD_W | Trailing-edge time, low word |
| trail_hi_o | output | WORD_W | Trailing-edge time, high word |
| drop_count_o | output | DROP_W | Saturating count of lost records |
| irq_data_o | output | 1 | Level interrupt: a record is waiting |
| irq_full_o | output | 1 | Level interrupt: records are being lost |

## Verification
A pointer or occupancy count that drifts shows up at the ports on the next handshake. The record delivered after a clear is out of order or repeated. The loss warning also rises one entry early or late while the queue is being filled to capacity. A reader state that skips its wait shows up within one cycle of the next arrival, as read words changing while bit 2 is still set. A missed flush leaves stale records that surface two cycles after the run bit returns to 1.

// File: rtl/pulse_rec_pkg.sv
package pulse_rec_pkg;
    localparam int CTL_W     = 8;
    localparam int BIT_RUN   = 0;
    localparam int BIT_PAUSE = 1;
    localparam int BIT_HS    = 2;
    localparam int BIT_WARN  = 3;
    localparam int NWORDS    = 4;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_HOLD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/prf_queue.sv
module prf_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  logic                         pop_i,
    input  logic [W-1:0]                 data_i,
    output logic [W-1:0]                 head_o,
    output logic                         full_o,
    output logic                         empty_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } q_state_t;

    q_state_t q_d, q_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        q_d = q_q;
        if (flush_i) begin
            q_d = '0;
        end else begin
            if (push_i) q_d.wr_ptr = ptr_next(q_q.wr_ptr);
            if (pop_i)  q_d.rd_ptr = ptr_next(q_q.rd_ptr);
            case ({push_i, pop_i})
                2'b10:   q_d.cnt = q_q.cnt + CNT_W'(1);
                2'b01:   q_d.cnt = q_q.cnt - CNT_W'(1);
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    // storage array carries no reset; only written entries are ever read
    always_ff @(posedge clk) begin
        if (push_i && !flush_i) mem_q[q_q.wr_ptr] <= data_i;
    end

    assign head_o  = mem_q[q_q.rd_ptr];
    assign full_o  = (q_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (q_q.cnt == '0);
    assign count_o = q_q.cnt;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CNT_W'(DEPTH));
    p_push_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && full_o && !pop_i));
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && empty_o));
endmodule

// File: rtl/prf_writer.sv
module prf_writer #(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              pause_n_i,
    input  logic              rec_valid_i,
    input  logic              full_i,
    input  logic              pop_i,
    output logic              push_o,
    output logic [DROP_W-1:0] drop_cnt_o,
    output logic              warn_o
);
    typedef struct packed {
        logic [DROP_W-1:0] drops;
        logic              warn;
    } wr_state_t;

    wr_state_t w_d, w_q;
    logic offer, room, drop;

    always_comb begin
        offer  = rec_valid_i && pause_n_i && !flush_i;
        room   = !full_i || pop_i;
        push_o = offer && room;
        drop   = offer && !room;

        w_d = w_q;
        if (flush_i) begin
            w_d = '0;
        end else if (drop) begin
            w_d.warn = 1'b1;
            if (w_q.drops != '1) w_d.drops = w_q.drops + DROP_W'(1);
        end else if (!full_i) begin
            w_d.warn = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign drop_cnt_o = w_q.drops;
    assign warn_o     = w_q.warn;

    p_drop_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.drops == '1 && !flush_i) |=> (w_q.drops == '1));
    p_warn_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.warn && !full_i && !rec_valid_i) |=> !w_q.warn);
endmodule

// File: rtl/prf_reader.sv
module prf_reader
    import pulse_rec_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       clr_req_i,
    input  logic                       empty_i,
    input  logic [NWORDS*WORD_W-1:0]   head_i,
    output logic                       pop_o,
    output logic                       hs_o,
    output logic [NWORDS*WORD_W-1:0]   rec_o
);
    localparam int REC_W = NWORDS * WORD_W;

    typedef struct packed {
        rd_state_e        st;
        logic [REC_W-1:0] rec;
    } rd_t;

    rd_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        pop_o = 1'b0;
        if (flush_i) begin
            r_d.st  = RD_IDLE;
            r_d.rec = '0;
        end else begin
            case (r_q.st)
                RD_IDLE: begin
                    if (!empty_i) begin
                        pop_o   = 1'b1;
                        r_d.rec = head_i;
                        r_d.st  = RD_HOLD;
                    end
                end
                RD_HOLD: begin
                    if (clr_req_i) r_d.st = RD_IDLE;
                end
                default: r_d.st = RD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= RD_IDLE;
            r_q.rec <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_o  = (r_q.st == RD_HOLD);
    assign rec_o = r_q.rec;

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RD_HOLD && !clr_req_i && !flush_i) |=> $stable(r_q.rec));
    p_clear_drops_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RD_HOLD && clr_req_i) |=> (r_q.st == RD_IDLE));
    p_load_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RD_IDLE && !empty_i && !flush_i) |=> (r_q.st == RD_HOLD));
endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
    import pulse_rec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    input  logic             hs_i,
    input  logic             warn_i,
    output logic             run_o,
    output logic             pause_n_o,
    output logic             clr_req_o,
    output logic [CTL_W-1:0] rd_o
);
    typedef struct packed {
        logic run;
        logic pause_n;
    } ctl_t;

    ctl_t c_d, c_q;
    logic unused_wr_bits;

    always_comb begin
        c_d = c_q;
        if (wr_en_i) begin
            c_d.run     = wr_data_i[BIT_RUN];
            c_d.pause_n = wr_data_i[BIT_PAUSE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.run     <= 1'b1;
            c_q.pause_n <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    // a zero in the handshake position is a clear request; a one does nothing
    assign clr_req_o      = wr_en_i && !wr_data_i[BIT_HS];
    assign unused_wr_bits = ^wr_data_i[CTL_W-1:BIT_WARN];
    assign run_o          = c_q.run;
    assign pause_n_o      = c_q.pause_n;

    always_comb begin
        rd_o            = '0;
        rd_o[BIT_RUN]   = c_q.run;
        rd_o[BIT_PAUSE] = c_q.pause_n;
        rd_o[BIT_HS]    = hs_i;
        rd_o[BIT_WARN]  = warn_i;
    end
endmodule

// File: rtl/pulse_rec_fifo.sv
module pulse_rec_fifo
    import pulse_rec_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int DROP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rec_valid_i,
    input  logic [4*WORD_W-1:0]      rec_data_i,
    input  logic                     ctl_wr_en_i,
    input  logic [7:0]               ctl_wr_data_i,
    output logic [7:0]               ctl_rd_data_o,
    output logic [WORD_W-1:0]        lead_lo_o,
    output logic [WORD_W-1:0]        lead_hi_o,
    output logic [WORD_W-1:0]        trail_lo_o,
    output logic [WORD_W-1:0]        trail_hi_o,
    output logic [DROP_W-1:0]        drop_count_o,
    output logic                     irq_data_o,
    output logic                     irq_full_o
);
    localparam int REC_W = NWORDS * WORD_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             run, pause_n, clr_req, flush;
    logic             push, pop, q_full, q_empty, hs, warn;
    logic [CNT_W-1:0] q_count;
    logic [REC_W-1:0] q_head, rd_rec;
    logic [NWORDS-1:0][WORD_W-1:0] words;

    assign flush = !run;

    prf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (ctl_wr_en_i),
        .wr_data_i (ctl_wr_data_i),
        .hs_i      (hs),
        .warn_i    (warn),
        .run_o     (run),
        .pause_n_o (pause_n),
        .clr_req_o (clr_req),
        .rd_o      (ctl_rd_data_o)
    );

    prf_writer #(.DROP_W(DROP_W)) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .pause_n_i   (pause_n),
        .rec_valid_i (rec_valid_i),
        .full_i      (q_full),
        .pop_i       (pop),
        .push_o      (push),
        .drop_cnt_o  (drop_count_o),
        .warn_o      (warn)
    );

    prf_queue #(.DEPTH(DEPTH), .W(REC_W)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .push_i  (push),
        .pop_i   (pop),
        .data_i  (rec_data_i),
        .head_o  (q_head),
        .full_o  (q_full),
        .empty_o (q_empty),
        .count_o (q_count)
    );

    prf_reader #(.WORD_W(WORD_W)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .clr_req_i (clr_req),
        .empty_i   (q_empty),
        .head_i    (q_head),
        .pop_o     (pop),
        .hs_o      (hs),
        .rec_o     (rd_rec)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NWORDS; gi++) begin : g_split
            assign words[gi] = rd_rec[gi*WORD_W +: WORD_W];
        end
    endgenerate

    assign lead_lo_o  = words[0];
    assign lead_hi_o  = words[1];
    assign trail_lo_o = words[2];
    assign trail_hi_o = words[3];
    assign irq_data_o = hs;
    assign irq_full_o = warn;

    p_rise_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs) |-> $past(!q_empty));
    p_warn_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn) |-> $past(q_full));
    p_pause_no_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause_n) |=> (q_count <= $past(q_count)));
    p_flush_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (q_empty && !hs && !warn && drop_count_o == '0));
endmodule

// File: tb/pulse_rec_fifo_tb.sv
`timescale 1ns/1ps
module pulse_rec_fifo_tb;
    localparam int DEPTH  = 16;
    localparam int WORD_W = 32;
    localparam int DROP_W = 8;
    localparam int REC_W  = 4 * WORD_W;
    localparam int NTBL   = 6;

    localparam logic [REC_W-1:0] TBL [NTBL] = '{
        128'h4401_0004_3301_0003_2201_0002_1101_0001,
        128'h8802_0080_7702_0070_6602_0060_5502_0050,
        128'hFFFF_0000_0000_FFFF_AAAA_5555_5555_AAAA,
        128'h0000_0001_0000_0000_FFFF_FFFF_8000_0000,
        128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321,
        128'h0BAD_F00D_DEAD_BEEF_CAFE_D00D_0000_0007
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rec_valid = 1'b0;
    logic [REC_W-1:0]  rec_data = '0;
    logic              ctl_wr_en = 1'b0;
    logic [7:0]        ctl_wr_data = '0;
    logic [7:0]        ctl_rd;
    logic [WORD_W-1:0] lead_lo, lead_hi, trail_lo, trail_hi;
    logic [DROP_W-1:0] drops;
    logic              irq_data, irq_full;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pulse_rec_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W), .DROP_W(DROP_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rec_valid_i   (rec_valid),
        .rec_data_i    (rec_data),
        .ctl_wr_en_i   (ctl_wr_en),
        .ctl_wr_data_i (ctl_wr_data),
        .ctl_rd_data_o (ctl_rd),
        .lead_lo_o     (lead_lo),
        .lead_hi_o     (lead_hi),
        .trail_lo_o    (trail_lo),
        .trail_hi_o    (trail_hi),
        .drop_count_o  (drops),
        .irq_data_o    (irq_data),
        .irq_full_o    (irq_full)
    );

    function automatic logic [REC_W-1:0] rec_of(input int i);
        return {32'hD000_0000 | 32'(i), 32'hC000_0000 | 32'(i),
                32'hB000_0000 | 32'(i), 32'hA000_0000 | 32'(i)};
    endfunction

    function automatic logic [REC_W-1:0] shown();
        return {trail_hi, trail_lo, lead_hi, lead_lo};
    endfunction

    task automatic chk(input string tag, input logic [REC_W-1:0] act,
                       input logic [REC_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en   = 1'b0;
    endtask

    task automatic push_n(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            rec_valid = 1'b1;
            rec_data  = rec_of(base + i);
            @(negedge clk);
        end
        rec_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        report();
    end

    initial begin : main
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1: reset state
        chk("R1 ctl", REC_W'(ctl_rd), REC_W'(8'h03));
        chk("R1 irq", REC_W'({irq_data, irq_full}), '0);
        chk("R1 words", shown(), '0);
        chk("R1 drops", REC_W'(drops), '0);

        // R3: first record reaches the read words one edge after it is stored
        push_n(100, 1);
        chk("R3 hs early", REC_W'(ctl_rd[2]), '0);
        wait_n(1);
        chk("R3 hs set", REC_W'(ctl_rd[2]), REC_W'(1));
        chk("R3 irq", REC_W'(irq_data), REC_W'(1));
        chk("R2 lead_lo", REC_W'(lead_lo), REC_W'(32'hA000_0064));
        chk("R2 lead_hi", REC_W'(lead_hi), REC_W'(32'hB000_0064));
        chk("R2 trail_lo", REC_W'(trail_lo), REC_W'(32'hC000_0064));
        chk("R2 trail_hi", REC_W'(trail_hi), REC_W'(32'hD000_0064));

        // R4: words held while handshake set; reload after clear
        push_n(101, 1);
        wait_n(3);
        chk("R4 held", shown(), rec_of(100));
        ctl_write(8'h03);
        chk("R4 hs cleared", REC_W'(ctl_rd[2]), '0);
        wait_n(1);
        chk("R4 reload hs", REC_W'(ctl_rd[2]), REC_W'(1));
        chk("R4 reload words", shown(), rec_of(101));
        ctl_write(8'h03);
        wait_n(2);
        chk("R4 empty hs", REC_W'(irq_data), '0);

        // R5 / R11: writing ones does not set handshake, warning or reserved bits
        ctl_write(8'hFF);
        wait_n(2);
        chk("R5 no sw set", REC_W'(irq_data), '0);
        chk("R11 readback", REC_W'(ctl_rd), REC_W'(8'h03));

        // R2: arrival order from the vector table
        for (int i = 0; i < NTBL; i++) begin
            rec_valid = 1'b1;
            rec_data  = TBL[i];
            @(negedge clk);
        end
        rec_valid = 1'b0;
        wait_n(2);
        for (int i = 0; i < NTBL; i++) begin
            chk("R2 order hs", REC_W'(ctl_rd[2]), REC_W'(1));
            chk("R2 order word", shown(), TBL[i]);
            ctl_write(8'h03);
            wait_n(1);
        end
        chk("R2 drained", REC_W'(ctl_rd[2]), '0);

        // R6: paused path ignores records
        ctl_write(8'h01);
        push_n(150, 2);
        ctl_write(8'h03);
        wait_n(3);
        chk("R6 nothing stored", REC_W'(ctl_rd), REC_W'(8'h03));
        chk("R6 not lost", REC_W'(drops), '0);

        // R8: fill queue behind a held record, then lose one
        push_n(200, 1);
        push_n(201, DEPTH);
        wait_n(1);
        chk("R8 full no warn", REC_W'(ctl_rd[3]), '0);
        push_n(201 + DEPTH, 1);
        chk("R8 warn bit", REC_W'(ctl_rd[3]), REC_W'(1));
        chk("R8 irq_full", REC_W'(irq_full), REC_W'(1));
        chk("R8 lost one", REC_W'(drops), REC_W'(1));
        chk("R8 held word", shown(), rec_of(200));

        // R9: warning falls after one entry leaves
        ctl_write(8'h03);
        wait_n(1);
        chk("R9 next record", shown(), rec_of(201));
        wait_n(1);
        chk("R9 warn cleared", REC_W'(ctl_rd[3]), '0);
        chk("R9 irq_full low", REC_W'(irq_full), '0);

        // R10: saturation of the loss counter
        push_n(300, 300);
        wait_n(1);
        chk("R10 saturated", REC_W'(drops), REC_W'({DROP_W{1'b1}}));
        chk("R10 warn again", REC_W'(irq_full), REC_W'(1));

        // R7: run bit low flushes everything and discards offers
        ctl_write(8'h02);
        wait_n(1);
        chk("R7 ctl", REC_W'(ctl_rd), REC_W'(8'h02));
        chk("R7 drops", REC_W'(drops), '0);
        chk("R7 words", shown(), '0);
        chk("R7 irqs", REC_W'({irq_data, irq_full}), '0);
        push_n(350, 2);
        ctl_write(8'h03);
        wait_n(3);
        chk("R7 nothing kept", REC_W'(ctl_rd), REC_W'(8'h03));
        push_n(400, 1);
        wait_n(2);
        chk("R7 fresh record", shown(), rec_of(400));

        report();
    end
endmodule